// File: doc/BRIEF.md
# Paired-Page Translation Lookup Buffer

This block translates 32-bit virtual addresses to physical addresses through a small, fully associative table. Each table slot describes two neighbouring 4 KB virtual pages at once. The pair is aligned, so the lower page is the even half and the upper page is the odd half. Each half has its own physical frame, valid flag and dirty flag. A slot belongs either to every address space, through a global flag, or to a single 8-bit address-space identifier.

A lookup request arrives on a valid/ready channel. The request carries the virtual address, a write flag and the current address-space identifier. All slots are compared in parallel, and the lowest-numbered hit is selected. The address bit just above the page offset picks the half. One clock later a registered response appears on a second valid/ready channel. It carries a result code, the physical address and the read/write permissions.

Back-pressure works as follows. A response stays on the outputs, unchanged, until `rsp_ready` is high at a clock edge. A new request is accepted only when the response register is empty or is being drained in the same cycle. A plain load port writes one slot by index.

Top module: `pair_tlb`

## Requirements
- R1: A slot hits when its stored 19-bit tag equals address bits 31:13 and either its global flag is set or its stored identifier equals `req_asid`.
- R2: Address bit 12 selects the slot half (0 = even, 1 = odd). Bits 11:0 are not compared and pass unchanged into physical address bits 11:0.
- R3: If the selected half is not valid, the code is INVALID (2) for reads and writes alike, with `rsp_pa`, `rsp_rd` and `rsp_wr` all zero.
- R4: A write to a valid half whose dirty flag is clear yields code DIRTY (3), with `rsp_pa`, `rsp_rd` and `rsp_wr` all zero. A read never yields DIRTY.
- R5: A successful lookup yields code MATCH (0) and `rsp_pa` = {selected frame, bits 11:0}. `rsp_rd` is 1, and `rsp_wr` equals the selected half's dirty flag.
- R6: When no slot hits, the code is NOMATCH (1), with `rsp_pa`, `rsp_rd` and `rsp_wr` all zero.
- R7: When several slots hit, the slot with the lowest index supplies the result.
- R8: A request accepted at an edge (`req_valid` && `req_ready`) produces its response at that edge, with `rsp_valid` high. `rsp_valid` remains high, with a stable payload, until an edge with `rsp_ready` high. `req_ready` = !`rsp_valid` || `rsp_ready`.
- R9: A slot load takes effect at the clock edge. A lookup accepted at that same edge still sees the slot's previous contents.
- R10: Reset sets every field of every slot to zero, including all valid flags, and clears `rsp_valid`. After reset no lookup returns MATCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store access, 0 = load access |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_code | output | 3 | 0 MATCH, 1 NOMATCH, 2 INVALID, 3 DIRTY |
| rsp_pa | output | 32 | Physical address (zero unless MATCH) |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| ld_en | input | 1 | Load one slot |
| ld_idx | input | 4 | Slot index to load |
| ld_tag | input | 19 | Page-pair tag (virtual address bits 31:13) |
| ld_asid | input | 8 | Owning identifier |
| ld_global | input | 1 | Slot matches any identifier |
| ld_pfn_even | input | 20 | Frame for the even half |
| ld_pfn_odd | input | 20 | Frame for the odd half |
| ld_valid | input | 2 | Valid flags, bit 0 even, bit 1 odd |
| ld_dirty | input | 2 | Dirty flags, bit 0 even, bit 1 odd |

## Verification
The bench builds the block with its defaults: 16 slots, 8-bit identifiers and 20-bit frames. Random slot tags are drawn from only eight values and identifiers from only four. This makes multi-slot hits, identifier mismatches and global overrides frequent, so the lowest-index priority and the half selection are exercised heavily by random traffic. Directed cases cover the following:
- the zeroed state after reset;
- a load and a lookup at the same edge;
- a held response under back-pressure, with a second request waiting behind it.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3
  } tlb_res_e;
endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store #(
  parameter int N      = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic              ld_global,
  input  logic [PFN_W-1:0]  ld_pfn_even,
  input  logic [PFN_W-1:0]  ld_pfn_odd,
  input  logic [1:0]        ld_valid,
  input  logic [1:0]        ld_dirty,
  output logic [TAG_W-1:0]  tag_q  [N],
  output logic [ASID_W-1:0] asid_q [N],
  output logic              glob_q [N],
  output logic [PFN_W-1:0]  pfn_q  [N][2],
  output logic [1:0]        val_q  [N],
  output logic [1:0]        dirty_q[N]
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic sel;
    assign sel = ld_en && (ld_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i]    <= '0;
        asid_q[i]   <= '0;
        glob_q[i]   <= 1'b0;
        pfn_q[i][0] <= '0;
        pfn_q[i][1] <= '0;
        val_q[i]    <= '0;
        dirty_q[i]  <= '0;
      end else if (sel) begin
        tag_q[i]    <= ld_tag;
        asid_q[i]   <= ld_asid;
        glob_q[i]   <= ld_global;
        pfn_q[i][0] <= ld_pfn_even;
        pfn_q[i][1] <= ld_pfn_odd;
        val_q[i]    <= ld_valid;
        dirty_q[i]  <= ld_dirty;
      end
    end
  end
endmodule

// File: rtl/pair_tlb_match.sv
module pair_tlb_match #(
  parameter int N      = 16,
  parameter int TAG_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic [TAG_W-1:0]  va_tag,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [TAG_W-1:0]  tag_q [N],
  input  logic [ASID_W-1:0] asid_q[N],
  input  logic              glob_q[N],
  output logic [N-1:0]      hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = (tag_q[i] == va_tag) && (glob_q[i] || (asid_q[i] == cur_asid));
  end
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     hit,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end
  assign any = |hit;
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb #(
  parameter int N         = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  parameter int PFN_W     = 20,
  localparam int IDX_W    = (N > 1) ? $clog2(N) : 1,
  localparam int TAG_W    = VA_W - PAGE_BITS - 1,
  localparam int PA_W     = PFN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic              ld_global,
  input  logic [PFN_W-1:0]  ld_pfn_even,
  input  logic [PFN_W-1:0]  ld_pfn_odd,
  input  logic [1:0]        ld_valid,
  input  logic [1:0]        ld_dirty
);
  import pair_tlb_pkg::*;

  logic [TAG_W-1:0]  tag_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic              glob_q [N];
  logic [PFN_W-1:0]  pfn_q  [N][2];
  logic [1:0]        val_q  [N];
  logic [1:0]        dirty_q[N];

  pair_tlb_store #(.N(N), .IDX_W(IDX_W), .TAG_W(TAG_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_asid(ld_asid),
    .ld_global(ld_global), .ld_pfn_even(ld_pfn_even), .ld_pfn_odd(ld_pfn_odd),
    .ld_valid(ld_valid), .ld_dirty(ld_dirty),
    .tag_q(tag_q), .asid_q(asid_q), .glob_q(glob_q),
    .pfn_q(pfn_q), .val_q(val_q), .dirty_q(dirty_q)
  );

  // Address split: tag above the half-select bit, offset below it.
  logic [TAG_W-1:0]     va_tag;
  logic                 va_odd;
  logic [PAGE_BITS-1:0] va_off;
  assign va_tag = req_va[VA_W-1 -: TAG_W];
  assign va_odd = req_va[PAGE_BITS];
  assign va_off = req_va[PAGE_BITS-1:0];

  logic [N-1:0] hit;
  pair_tlb_match #(.N(N), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_match (
    .va_tag(va_tag), .cur_asid(req_asid),
    .tag_q(tag_q), .asid_q(asid_q), .glob_q(glob_q), .hit(hit)
  );

  logic             any_hit;
  logic [IDX_W-1:0] win;
  pair_tlb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .hit(hit), .any(any_hit), .idx(win)
  );

  // Half selection and permission checks on the winning slot.
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_v, sel_d;
  assign sel_pfn = pfn_q[win][va_odd];
  assign sel_v   = val_q[win][va_odd];
  assign sel_d   = dirty_q[win][va_odd];

  tlb_res_e        nx_code;
  logic [PA_W-1:0] nx_pa;
  logic            nx_rd, nx_wr;

  always_comb begin
    nx_code = RES_NOMATCH;
    nx_pa   = '0;
    nx_rd   = 1'b0;
    nx_wr   = 1'b0;
    if (any_hit) begin
      if (!sel_v) begin
        nx_code = RES_INVALID;
      end else if (req_write && !sel_d) begin
        nx_code = RES_DIRTY;
      end else begin
        nx_code = RES_MATCH;
        nx_pa   = {sel_pfn, va_off};
        nx_rd   = 1'b1;
        nx_wr   = sel_d;
      end
    end
  end

  // Response register with valid/ready back-pressure.
  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  tlb_res_e code_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      code_q    <= RES_NOMATCH;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      code_q    <= nx_code;
      rsp_pa    <= nx_pa;
      rsp_rd    <= nx_rd;
      rsp_wr    <= nx_wr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
  assign rsp_code = code_q;
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_code,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_rd,
  input logic            rsp_wr
);
  import pair_tlb_pkg::*;

  assert_match_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RES_MATCH) |-> rsp_rd);

  assert_wr_implies_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr |-> rsp_rd);

  assert_fault_zeroed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RES_MATCH) |-> (!rsp_rd && !rsp_wr && rsp_pa == '0));

  assert_read_never_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (rsp_code != RES_DIRTY));

  assert_accept_gives_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_pa)
                                   && $stable(rsp_rd) && $stable(rsp_wr)));

  assert_no_accept_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind pair_tlb pair_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr)
);

// File: tb/pair_tlb_tb_top.sv
module pair_tlb_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        req_ready, rsp_valid, rsp_rd, rsp_wr;
  logic [2:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic        ld_en = 1'b0, ld_global = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [18:0] ld_tag = '0;
  logic [7:0]  ld_asid = '0;
  logic [19:0] ld_pfn_even = '0, ld_pfn_odd = '0;
  logic [1:0]  ld_valid = '0, ld_dirty = '0;

  always #10 clk = ~clk;

  pair_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_asid(ld_asid),
    .ld_global(ld_global), .ld_pfn_even(ld_pfn_even), .ld_pfn_odd(ld_pfn_odd),
    .ld_valid(ld_valid), .ld_dirty(ld_dirty)
  );

  // Reference model of the slot table
  logic [18:0] m_tag [N];
  logic [7:0]  m_asid[N];
  logic        m_glob[N];
  logic [19:0] m_pfn [N][2];
  logic [1:0]  m_v   [N];
  logic [1:0]  m_d   [N];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Returns {code, pa, rd, wr}
  function automatic logic [36:0] expect_fn(logic [31:0] va, logic w, logic [7:0] asid);
    logic [2:0] c = 3'd1;
    logic [31:0] p = '0;
    logic r = 1'b0, wp = 1'b0;
    bit found = 1'b0;
    int k = 0;
    for (int i = 0; i < N; i++) begin
      if (!found && m_tag[i] == va[31:13] && (m_glob[i] || m_asid[i] == asid)) begin
        found = 1'b1;
        k = i;
      end
    end
    if (found) begin
      if (!m_v[k][va[12]]) c = 3'd2;
      else if (w && !m_d[k][va[12]]) c = 3'd3;
      else begin
        c = 3'd0;
        p = {m_pfn[k][va[12]], va[11:0]};
        r = 1'b1;
        wp = m_d[k][va[12]];
      end
    end
    return {c, p, r, wp};
  endfunction

  task automatic check_rsp(string req, logic [36:0] e);
    checks++;
    if (!rsp_valid || {rsp_code, rsp_pa, rsp_rd, rsp_wr} !== e) begin
      errors++;
      $display("FAIL %s: got valid=%0b code=%0d pa=%h rd=%0b wr=%0b, expected valid=1 code=%0d pa=%h rd=%0b wr=%0b",
               req, rsp_valid, rsp_code, rsp_pa, rsp_rd, rsp_wr,
               e[36:34], e[33:2], e[1], e[0]);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic model_load(int i, logic [18:0] t, logic [7:0] a, logic g,
                            logic [19:0] pe, logic [19:0] po, logic [1:0] v, logic [1:0] d);
    ld_en = 1'b1; ld_idx = 4'(i); ld_tag = t; ld_asid = a; ld_global = g;
    ld_pfn_even = pe; ld_pfn_odd = po; ld_valid = v; ld_dirty = d;
    m_tag[i] = t; m_asid[i] = a; m_glob[i] = g;
    m_pfn[i][0] = pe; m_pfn[i][1] = po; m_v[i] = v; m_d[i] = d;
  endtask

  task automatic load(int i, logic [18:0] t, logic [7:0] a, logic g,
                      logic [19:0] pe, logic [19:0] po, logic [1:0] v, logic [1:0] d);
    @(negedge clk);
    model_load(i, t, a, g, pe, po, v, d);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic lookup(string req, logic [31:0] va, logic w, logic [7:0] asid);
    logic [36:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = w; req_asid = asid;
    e = expect_fn(va, w, asid);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(req, e);
  endtask

  function automatic logic [31:0] mkva(logic [18:0] t, logic odd, logic [11:0] off);
    return {t, odd, off};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [36:0] e_old, e_a, e_b;
    for (int i = 0; i < N; i++) begin
      m_tag[i] = '0; m_asid[i] = '0; m_glob[i] = 1'b0;
      m_pfn[i][0] = '0; m_pfn[i][1] = '0; m_v[i] = '0; m_d[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check_bit("R10 rsp_valid after reset", rsp_valid, 1'b0);
    check_bit("R8 req_ready when empty", req_ready, 1'b1);
    lookup("R10 zeroed slot 0 is invalid", mkva(19'h0, 1'b0, 12'h010), 1'b0, 8'h00);
    lookup("R6 no hit after reset", mkva(19'h5, 1'b1, 12'h010), 1'b0, 8'h00);

    // Directed: slot 0 private to identifier 5, even dirty, odd clean
    load(0, 19'h10, 8'h05, 1'b0, 20'hAAAAA, 20'h55555, 2'b11, 2'b01);
    lookup("R5 even read", mkva(19'h10, 1'b0, 12'h123), 1'b0, 8'h05);
    lookup("R2 odd read offset pass", mkva(19'h10, 1'b1, 12'hABC), 1'b0, 8'h05);
    lookup("R4 odd write clean", mkva(19'h10, 1'b1, 12'h004), 1'b1, 8'h05);
    lookup("R5 even write dirty", mkva(19'h10, 1'b0, 12'hFFF), 1'b1, 8'h05);
    lookup("R1 identifier mismatch", mkva(19'h10, 1'b0, 12'h000), 1'b0, 8'h06);
    // Global slot with only odd half valid
    load(2, 19'h11, 8'h09, 1'b1, 20'h12345, 20'h6789A, 2'b10, 2'b11);
    lookup("R1 global overrides identifier", mkva(19'h11, 1'b1, 12'h321), 1'b0, 8'h06);
    lookup("R3 invalid half read", mkva(19'h11, 1'b0, 12'h321), 1'b0, 8'h06);
    lookup("R3 invalid half write", mkva(19'h11, 1'b0, 12'h321), 1'b1, 8'h06);
    // Priority between two hits
    load(7, 19'h20, 8'h00, 1'b1, 20'h00111, 20'h00111, 2'b11, 2'b11);
    load(4, 19'h20, 8'h00, 1'b1, 20'h00222, 20'h00222, 2'b11, 2'b11);
    lookup("R7 lowest index wins", mkva(19'h20, 1'b0, 12'h0AA), 1'b0, 8'h01);

    // R9: load and lookup at the same edge
    @(negedge clk);
    e_old = expect_fn(mkva(19'h20, 1'b0, 12'h055), 1'b0, 8'h01);
    req_valid = 1'b1; req_va = mkva(19'h20, 1'b0, 12'h055); req_write = 1'b0; req_asid = 8'h01;
    model_load(4, 19'h20, 8'h00, 1'b1, 20'h00333, 20'h00333, 2'b11, 2'b11);
    @(negedge clk);
    req_valid = 1'b0; ld_en = 1'b0;
    check_rsp("R9 same-edge lookup sees old slot", e_old);
    lookup("R9 next lookup sees new slot", mkva(19'h20, 1'b0, 12'h055), 1'b0, 8'h01);

    // R8: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_va = mkva(19'h10, 1'b0, 12'h111); req_write = 1'b0; req_asid = 8'h05;
    e_a = expect_fn(req_va, 1'b0, 8'h05);
    @(negedge clk);
    req_va = mkva(19'h10, 1'b1, 12'h222); req_write = 1'b1;
    e_b = expect_fn(req_va, 1'b1, 8'h05);
    check_bit("R8 req_ready low while stalled", req_ready, 1'b0);
    @(negedge clk);
    check_rsp("R8 response held under stall", e_a);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R8 queued request after drain", e_b);
    @(negedge clk);
    check_bit("R8 rsp_valid drops after drain", rsp_valid, 1'b0);

    // Constrained random traffic
    void'($urandom(32'd2024));
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 4 == 0) begin
        load(int'($urandom % N), 19'($urandom % 8), 8'($urandom % 4), 1'($urandom % 4 == 0),
             20'($urandom), 20'($urandom), 2'($urandom), 2'($urandom));
      end else begin
        lookup("R1 R2 R7 random lookup",
               mkva(19'($urandom % 8), 1'($urandom), 12'($urandom)),
               1'($urandom), 8'($urandom % 4));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule